// File: doc/BRIEF.md
# Cache Event Performance Counter Unit

This block counts events from a shared cache for performance analysis. It holds a set of wide counters. Each counter picks one event source through a programmable 8-bit code and advances by one in every clock cycle where the selected event pulse is high. A counter runs only while two things are set: its own enable bit and one global run bit. When a counter wraps past its largest value, it latches a per-counter overflow flag. Each flag can be masked from the interrupt line or cleared by writing a one.

Software uses a simple memory-mapped register bus. A write completes on the clock edge where it is presented. Read data is returned one cycle after the read strobe. Software may preload any counter. This lets it set the distance to the next overflow, so that a sampling interrupt fires after a chosen number of events. The event input is a vector of single-cycle pulses, indexed by event code.

Top module: `evcu_top`

## Requirements
- R1: After reset, every counter, every per-counter enable bit, the global run bit and every overflow flag are 0. Every interrupt mask bit is 1. Every event code byte is 0xFF. The irq output is 0.
- R2: Counter n is a 64-bit register at address 0x1E00 + 8*n. A write loads bits 47:0 at the write's clock edge. Writes to bits 63:48 are ignored, and those bits always read as 0.
- R3: The event code of counter n is byte n%4, at bits 8*(n%4)+7 : 8*(n%4), of the 32-bit select word at address 0x1D00 + 4*(n/4). The select words read back as written.
- R4: A counter whose code is 0xFF never advances. A code outside the set {0x00-0x04, 0x20-0x23, 0x29, 0x40-0x42} also never advances the counter, whatever the pulse vector shows.
- R5: A counter advances by exactly 1 on a clock edge only if all three hold: evt_pulse[code] is 1, bit 16 of the control word at 0x0408 is 1, and bit n of the enable word at 0x1C00 is 1. In every other case it holds its value.
- R6: Bit n of the mask word at 0x0800 masks counter n's flag when it is 1. irq is a register that takes the OR of the unmasked overflow flags one cycle later.
- R7: On the edge where counter n advances from 2^48-1 to 0, bit n of the overflow status word at 0x0808 becomes 1.
- R8: Writing to address 0x080C clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R9: If a wrap and a clear hit the same status bit on the same edge, the bit ends up set.
- R10: A software write to a counter on the same edge as an increment of that counter wins, and the counter takes the written value.
- R11: A read strobe at one edge gives reg_rvalid = 1 and the addressed register's value on reg_rdata after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Byte address of the register |
| reg_wdata | input | 64 | Write data (32-bit registers use bits 31:0) |
| reg_rdata | output | 64 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| evt_pulse | input | 256 | Event pulses, bit index equals event code |
| irq | output | 1 | Overflow interrupt, registered |

## Verification
Counting is first driven with every pulse high while the global bit is clear. This separates the global gate from the per-counter enable. The per-counter gate is then tested alone by dropping one enable bit with the global bit set. Reserved and unsupported codes are driven with a fully set pulse vector, so any leak through the code filter shows up as a nonzero count. Single-bit pulse patterns on preloaded counters show exact wrap, flag and interrupt timing. They also show which side wins when a write or a clear lands on the same edge as an increment or a wrap. A long run of random pulse vectors is mixed with random near-wrap preloads, mask changes, enable changes and clears. This run compares every counter and the status word against a cycle-accurate reference model kept in the bench.

// File: rtl/evcu_pkg.sv
package evcu_pkg;
  localparam int ADDR_W   = 16;
  localparam int CODE_W   = 8;
  localparam int GLOB_BIT = 16;

  localparam logic [CODE_W-1:0] CODE_NONE = 8'hFF;

  localparam logic [ADDR_W-1:0] A_CTRL = 16'h0408;
  localparam logic [ADDR_W-1:0] A_MASK = 16'h0800;
  localparam logic [ADDR_W-1:0] A_STAT = 16'h0808;
  localparam logic [ADDR_W-1:0] A_CLR  = 16'h080C;
  localparam logic [ADDR_W-1:0] A_EN   = 16'h1C00;
  localparam logic [ADDR_W-1:0] A_SEL  = 16'h1D00;
  localparam logic [ADDR_W-1:0] A_CNT  = 16'h1E00;

  // Codes that are wired to a cache event source
  function automatic logic code_known(input logic [CODE_W-1:0] c);
    logic k;
    case (c)
      8'h00, 8'h01, 8'h02, 8'h03, 8'h04,
      8'h20, 8'h21, 8'h22, 8'h23, 8'h29,
      8'h40, 8'h41, 8'h42: k = 1'b1;
      default:             k = 1'b0;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/evcu_cfg.sv
module evcu_cfg
  import evcu_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int NUM_SEL = (NUM_CNT + 3) / 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [31:0]              wdata,
  output logic                     glob_en,
  output logic [NUM_CNT-1:0]       cnt_en,
  output logic [NUM_CNT-1:0]       irq_mask,
  output logic [NUM_CNT*CODE_W-1:0] codes,
  output logic [NUM_SEL*32-1:0]    sel_words
);

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en  <= 1'b0;
      cnt_en   <= '0;
      irq_mask <= '1;
    end else if (wr_en) begin
      if (addr == A_CTRL) glob_en  <= wdata[GLOB_BIT];
      if (addr == A_EN)   cnt_en   <= wdata[NUM_CNT-1:0];
      if (addr == A_MASK) irq_mask <= wdata[NUM_CNT-1:0];
    end
  end

  // One 32-bit select word per group of four counters
  for (genvar k = 0; k < NUM_SEL; k++) begin : g_sel
    localparam logic [ADDR_W-1:0] WADDR = A_SEL + ADDR_W'(4 * k);
    always_ff @(posedge clk) begin
      if (rst)                          sel_words[32*k +: 32] <= '1;
      else if (wr_en && addr == WADDR)  sel_words[32*k +: 32] <= wdata;
    end
  end

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_code
    assign codes[CODE_W*n +: CODE_W] = sel_words[32*(n/4) + 8*(n%4) +: CODE_W];
  end

endmodule

// File: rtl/evcu_ctr.sv
module evcu_ctr
  import evcu_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int NUM_EVT = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  input  logic [NUM_EVT-1:0] evt_vec,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              wrap
);

  logic hit;
  assign hit  = run && (code != CODE_NONE) && code_known(code) && evt_vec[code];
  assign wrap = hit && !wr_en && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (wr_en) cnt_q <= wr_data;
    else if (hit)   cnt_q <= cnt_q + 1'b1;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en) |=> $stable(cnt_q)); // R5
  AST_NULL_CODE: assert property (@(posedge clk) disable iff (rst)
    (code == CODE_NONE && !wr_en) |=> $stable(cnt_q)); // R4
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cnt_q == $past(wr_data)); // R10

endmodule

// File: rtl/evcu_ovf.sv
module evcu_ovf #(
  parameter int NUM_CNT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] wrap,
  input  logic               clr_en,
  input  logic [NUM_CNT-1:0] clr_bits,
  input  logic [NUM_CNT-1:0] mask,
  output logic [NUM_CNT-1:0] status_q,
  output logic               irq_q
);

  logic [NUM_CNT-1:0] clr_sel;
  assign clr_sel = clr_en ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_sel) | wrap;
      irq_q    <= |(status_q & ~mask);
    end
  end

  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (rst)
    (|wrap) |=> ((status_q & $past(wrap)) == $past(wrap))); // R7
  AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> ((status_q & $past(clr_bits) & ~$past(wrap)) == '0)); // R8
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (&mask) |=> !irq_q); // R6

endmodule

// File: rtl/evcu_top.sv
module evcu_top
  import evcu_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 48,
  parameter int DATA_W  = 64,
  parameter int NUM_EVT = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_rvalid,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic               irq
);

  localparam int NUM_SEL = (NUM_CNT + 3) / 4;
  localparam int IDX_W   = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam logic [ADDR_W-1:0] CNT_SPAN = ADDR_W'(8 * NUM_CNT);

  logic                      glob_en;
  logic [NUM_CNT-1:0]        cnt_en, irq_mask, wrap, status;
  logic [NUM_CNT*CODE_W-1:0] codes;
  logic [NUM_SEL*32-1:0]     sel_words;
  logic [CNT_W-1:0]          cnt_q [NUM_CNT];
  logic [ADDR_W-1:0]         cnt_off;
  logic [IDX_W-1:0]          cnt_idx;
  logic                      cnt_hit, clr_en;
  logic [DATA_W-1:0]         rd_mux;
  logic                      unused_hi;

  assign unused_hi = ^reg_wdata[DATA_W-1:CNT_W];

  // Counter window decode: 8-byte stride, aligned accesses only
  assign cnt_off = reg_addr - A_CNT;
  assign cnt_idx = cnt_off[3 +: IDX_W];
  assign cnt_hit = (reg_addr >= A_CNT) && (cnt_off < CNT_SPAN) && (cnt_off[2:0] == 3'd0);
  assign clr_en  = reg_wr && (reg_addr == A_CLR);

  evcu_cfg #(.NUM_CNT(NUM_CNT), .NUM_SEL(NUM_SEL)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata[31:0]),
    .glob_en   (glob_en),
    .cnt_en    (cnt_en),
    .irq_mask  (irq_mask),
    .codes     (codes),
    .sel_words (sel_words)
  );

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_ctr
    logic ctr_wr;
    assign ctr_wr = reg_wr && cnt_hit && (cnt_idx == IDX_W'(n));
    evcu_ctr #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .run     (glob_en && cnt_en[n]),
      .code    (codes[CODE_W*n +: CODE_W]),
      .evt_vec (evt_pulse),
      .wr_en   (ctr_wr),
      .wr_data (reg_wdata[CNT_W-1:0]),
      .cnt_q   (cnt_q[n]),
      .wrap    (wrap[n])
    );
  end

  evcu_ovf #(.NUM_CNT(NUM_CNT)) u_ovf (
    .clk      (clk),
    .rst      (rst),
    .wrap     (wrap),
    .clr_en   (clr_en),
    .clr_bits (reg_wdata[NUM_CNT-1:0]),
    .mask     (irq_mask),
    .status_q (status),
    .irq_q    (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (cnt_hit) begin
      rd_mux = DATA_W'(cnt_q[cnt_idx]);
    end else begin
      case (reg_addr)
        A_CTRL:  rd_mux[GLOB_BIT]    = glob_en;
        A_EN:    rd_mux[NUM_CNT-1:0] = cnt_en;
        A_MASK:  rd_mux[NUM_CNT-1:0] = irq_mask;
        A_STAT:  rd_mux[NUM_CNT-1:0] = status;
        default: begin
          for (int k = 0; k < NUM_SEL; k++) begin
            if (reg_addr == A_SEL + ADDR_W'(4 * k)) rd_mux[31:0] = sel_words[32*k +: 32];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid); // R11
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && cnt_hit) |=> reg_rdata[DATA_W-1:CNT_W] == '0); // R2

endmodule

// File: tb/evcu_top_bench.sv
`timescale 1ns/1ps
module evcu_top_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0]  reg_addr = '0;
  logic [63:0]  reg_wdata = '0;
  logic [63:0]  reg_rdata;
  logic         reg_rvalid;
  logic [255:0] evt = '0;
  logic         irq;

  int checks = 0;
  int errors = 0;

  // Reference state, built from the requirements
  logic [47:0] m_cnt [8];
  logic [7:0]  m_sel [8];
  logic        m_glob;
  logic [7:0]  m_en, m_mask, m_st;

  always #4 clk = ~clk;

  evcu_top u_evcu_top (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .evt_pulse(evt), .irq(irq)
  );

  function automatic bit known(input logic [7:0] c);
    return (c <= 8'h04) || (c >= 8'h20 && c <= 8'h23) || (c == 8'h29) ||
           (c >= 8'h40 && c <= 8'h42);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit w, input bit r, input logic [15:0] a,
                     input logic [63:0] d, input logic [255:0] ev);
    logic [7:0] wr_bits;
    @(negedge clk);
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; evt = ev;
    @(posedge clk);
    wr_bits = '0;
    for (int n = 0; n < 8; n++) begin
      if (w && a == 16'h1E00 + 16'(8 * n)) m_cnt[n] = d[47:0];
      else if (m_glob && m_en[n] && m_sel[n] != 8'hFF && known(m_sel[n]) && ev[m_sel[n]]) begin
        if (m_cnt[n] == '1) wr_bits[n] = 1'b1;
        m_cnt[n] = m_cnt[n] + 48'd1;
      end
    end
    if (w && a == 16'h080C) m_st = m_st & ~d[7:0];
    m_st = m_st | wr_bits;
    if (w && a == 16'h0408) m_glob = d[16];
    if (w && a == 16'h1C00) m_en = d[7:0];
    if (w && a == 16'h0800) m_mask = d[7:0];
    for (int n = 0; n < 8; n++) begin
      if (w && a == 16'h1D00 + 16'(4 * (n / 4))) m_sel[n] = d[8*(n%4) +: 8];
    end
    #1;
    reg_wr = 1'b0; reg_rd = 1'b0; evt = '0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    cyc(1'b1, 1'b0, a, d, '0);
  endtask

  task automatic rdchk(input string req, input logic [15:0] a, input logic [63:0] exp);
    cyc(1'b0, 1'b1, a, '0, '0);
    @(negedge clk);
    chk("R11", 64'(reg_rvalid), 64'd1);
    chk(req, reg_rdata, exp);
  endtask

  task automatic chk_all(input string req);
    for (int n = 0; n < 8; n++) rdchk(req, 16'h1E00 + 16'(8 * n), {16'h0, m_cnt[n]});
    rdchk("R7", 16'h0808, {56'h0, m_st});
  endtask

  task automatic chk_irq(input string req, input logic exp);
    cyc(1'b0, 1'b0, '0, '0, '0);
    @(negedge clk);
    chk(req, 64'(irq), 64'(exp));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [47:0] keep0;
    void'($urandom(32'd4242));
    for (int n = 0; n < 8; n++) begin m_cnt[n] = '0; m_sel[n] = 8'hFF; end
    m_glob = 1'b0; m_en = '0; m_mask = 8'hFF; m_st = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rdchk("R1", 16'h1E00, 64'h0);
    rdchk("R1", 16'h1E38, 64'h0);
    rdchk("R1", 16'h0800, 64'hFF);
    rdchk("R1", 16'h1D00, 64'hFFFF_FFFF);
    rdchk("R1", 16'h1D04, 64'hFFFF_FFFF);
    rdchk("R1", 16'h0408, 64'h0);
    rdchk("R1", 16'h1C00, 64'h0);
    rdchk("R1", 16'h0808, 64'h0);
    chk_irq("R1", 1'b0);

    // R2 preload, upper bits ignored and read as zero
    wr(16'h1E10, 64'hABCD_0000_1234_5678);
    rdchk("R2", 16'h1E10, 64'h0000_0000_1234_5678);

    // R3 code bytes
    wr(16'h1D00, 64'h0302_0100);
    wr(16'h1D04, 64'h4229_2004);
    rdchk("R3", 16'h1D00, 64'h0302_0100);
    rdchk("R3", 16'h1D04, 64'h4229_2004);

    // R5 global gate closed
    wr(16'h1C00, 64'hFF);
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, '0, '0, '1);
    rdchk("R5", 16'h1E10, 64'h0000_0000_1234_5678);
    chk_all("R5");
    wr(16'h0408, 64'h1_0000);
    rdchk("R5", 16'h0408, 64'h1_0000);

    // R7 wrap sets flag, R6 mask
    wr(16'h1E00, 64'h0000_FFFF_FFFF_FFFF);
    cyc(1'b0, 1'b0, '0, '0, 256'h1);
    rdchk("R7", 16'h1E00, 64'h0);
    rdchk("R7", 16'h0808, 64'h1);
    chk_irq("R6", 1'b0);
    wr(16'h0800, 64'hFE);
    chk_irq("R6", 1'b1);
    wr(16'h0800, 64'hFF);
    chk_irq("R6", 1'b0);

    // R8 write-one-to-clear
    wr(16'h080C, 64'h0);
    rdchk("R8", 16'h0808, 64'h1);
    wr(16'h080C, 64'h1);
    rdchk("R8", 16'h0808, 64'h0);

    // R9 wrap and clear on the same edge
    wr(16'h1E08, 64'h0000_FFFF_FFFF_FFFF);
    cyc(1'b1, 1'b0, 16'h080C, 64'h2, 256'h2);
    rdchk("R9", 16'h0808, 64'h2);
    rdchk("R9", 16'h1E08, 64'h0);

    // R10 write beats increment
    cyc(1'b1, 1'b0, 16'h1E10, 64'd100, 256'h4);
    rdchk("R10", 16'h1E10, 64'd100);
    cyc(1'b0, 1'b0, '0, '0, 256'h4);
    rdchk("R5", 16'h1E10, 64'd101);

    // R4 reserved and unsupported codes
    wr(16'h1D04, 64'hFF80_FF05);
    for (int n = 4; n < 8; n++) wr(16'h1E00 + 16'(8 * n), 64'h0);
    for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, '0, '0, '1);
    for (int n = 4; n < 8; n++) rdchk("R4", 16'h1E00 + 16'(8 * n), 64'h0);
    wr(16'h1D04, 64'h4229_2004);
    wr(16'h080C, 64'hFF);

    // R5 per-counter gate
    wr(16'h1C00, 64'hFE);
    keep0 = m_cnt[0];
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, '0, '0, '1);
    rdchk("R5", 16'h1E00, {16'h0, keep0});
    chk_all("R5");
    wr(16'h1C00, 64'hFF);

    // Random pulses with near-wrap preloads, mask, enable and clear traffic
    for (int i = 0; i < 1200; i++) begin
      int unsigned r;
      logic [255:0] ev;
      r  = $urandom % 64;
      ev = {$urandom(), $urandom(), $urandom(), $urandom(),
            $urandom(), $urandom(), $urandom(), $urandom()};
      if (r == 0)
        cyc(1'b1, 1'b0, 16'h1E00 + 16'(8 * ($urandom % 8)),
            {16'hFFFF, 44'hFFF_FFFF_FFFF, 4'($urandom)}, ev);
      else if (r == 1) cyc(1'b1, 1'b0, 16'h0800, 64'($urandom % 256), ev);
      else if (r == 2) cyc(1'b1, 1'b0, 16'h1C00, 64'($urandom % 256), ev);
      else if (r == 3) cyc(1'b1, 1'b0, 16'h080C, 64'($urandom % 256), ev);
      else             cyc(1'b0, 1'b0, '0, '0, ev);
      if (i % 300 == 299) begin
        chk_all("R5");
        chk_irq("R6", |(m_st & ~m_mask));
      end
    end
    chk_all("R7");
    chk_irq("R6", |(m_st & ~m_mask));

    finish_run();
  end
endmodule